// File: doc/BRIEF.md
# Guarded Byte-Array Program/Erase Controller

This block owns a small sectored byte-wide storage array and refuses to change it unless software first performs a fixed unlock ritual. Software selects a page, writes two key bytes to a control register, and then writes the page number a second time. Only if both page values agree, and the sector that holds the page is not write-protected, does the controller open. While open, it accepts exactly one operation: a byte program inside the opened page, a page erase, or a mass erase. When that operation ends, the controller locks itself again.

Operation length is derived from a 16-bit frequency value that software loads before it starts work. A byte program lasts that many clock cycles. A page erase lasts four times as long, and a mass erase eight times as long. While a byte program runs, the storage-side port raises a stall flag. The control address is write-only for commands; reading the same address returns a status code. Array reads are combinational and always available.

Top module: `guarded_array_ctl`

## Requirements
- R1: After reset the status reads 0 (locked), the page, protection and frequency registers read 0, and every array byte reads FFH.
- R2: Register map: address 0 is control on write and status on read, 1 is page select, 2 is sector protection, 3 is frequency high byte and 4 is frequency low byte. Writing 73H to address 0 while locked gives status 1. Writing 8CH next gives status 2.
- R3: In status 2, a page-select write equal to the stored page value opens the controller (status 3). A different value returns it to status 0. The stored page value changes only on page-select writes made while locked. The page number is its low 4 bits, and each page holds 16 bytes.
- R4: In status 1 or 2, any register write other than the one expected returns the controller to status 0.
- R5: Protection bit k covers sector k, which holds bytes 32k to 32k+31. A write to the protection register can only set bits; only reset clears them. A page that lies in a protected sector never opens.
- R6: While open, an array write inside the opened page starts a byte program (status 4) that raises stall. When it completes, the byte holds its old value ANDed with the written data.
- R7: The frequency value F is {high, low}. A byte program stays busy for max(F,1) cycles.
- R8: While open, writing 95H to control erases the opened page (status 5) for 4*max(F,1) cycles. Every byte of that page becomes FFH, and no other page changes.
- R9: While open, writing 63H to control erases the whole array to FFH (status 6) for 8*max(F,1) cycles, but only if no protection bit is set. Otherwise the controller relocks and nothing is erased.
- R10: When any operation completes, the status returns to 0.
- R11: While busy (status 4 to 6), register writes and array writes have no effect.
- R12: While open, if a register write and an array write arrive in the same cycle, the register write decides the outcome and the array write is dropped.
- R13: An array write while not open has no effect. An array write outside the opened page while open has no effect and leaves the controller open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (status at address 0) |
| mem_wr | input | 1 | Array write strobe (program request) |
| mem_addr | input | 8 | Array byte address for read and write |
| mem_wdata | input | 8 | Array write data |
| mem_rdata | output | 8 | Array read data |
| stall | output | 1 | High while a byte program runs |

## Verification
In the open state, a command write to the control register and a program write to the array can arrive in the same cycle. The bench provokes this by driving both strobes on one clock edge, once with a non-command control byte. It then judges the outcome by the status, which must read locked, and by the targeted byte, which must still read FFH. Busy windows are checked the same way: the bench counts stall or busy-status cycles and compares the count with the figure derived from the frequency value.

// File: rtl/gac_pkg.sv
package gac_pkg;
  typedef enum logic [2:0] {
    ST_LOCKED = 3'd0,
    ST_STEP1  = 3'd1,
    ST_STEP2  = 3'd2,
    ST_OPEN   = 3'd3,
    ST_PROG   = 3'd4,
    ST_PERASE = 3'd5,
    ST_MERASE = 3'd6
  } gac_state_t;

  localparam logic [7:0] KEY_FIRST  = 8'h73;
  localparam logic [7:0] KEY_SECOND = 8'h8C;
  localparam logic [7:0] CMD_PAGE_ERASE = 8'h95;
  localparam logic [7:0] CMD_MASS_ERASE = 8'h63;

  localparam logic [2:0] RA_CTL  = 3'd0;
  localparam logic [2:0] RA_PAGE = 3'd1;
  localparam logic [2:0] RA_PROT = 3'd2;
  localparam logic [2:0] RA_FHI  = 3'd3;
  localparam logic [2:0] RA_FLO  = 3'd4;
endpackage

// File: rtl/gac_unlock_fsm.sv
module gac_unlock_fsm
  import gac_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_wr,
  input  logic [2:0] reg_addr,
  input  logic [7:0] reg_wdata,
  input  logic [7:0] page_q,
  input  logic       page_prot,
  input  logic       any_prot,
  input  logic       prog_req,
  input  logic       op_done,
  output gac_state_t state_q,
  output logic       start_prog,
  output logic       start_perase,
  output logic       start_merase
);
  gac_state_t state_d;
  logic ctl_wr;
  logic pg_wr;

  assign ctl_wr = reg_wr && (reg_addr == RA_CTL);
  assign pg_wr  = reg_wr && (reg_addr == RA_PAGE);

  always_comb begin
    state_d      = state_q;
    start_prog   = 1'b0;
    start_perase = 1'b0;
    start_merase = 1'b0;
    case (state_q)
      ST_LOCKED: begin
        if (ctl_wr && reg_wdata == KEY_FIRST) state_d = ST_STEP1;
      end
      ST_STEP1: begin
        if (reg_wr) state_d = (ctl_wr && reg_wdata == KEY_SECOND) ? ST_STEP2 : ST_LOCKED;
      end
      ST_STEP2: begin
        if (reg_wr) state_d = (pg_wr && reg_wdata == page_q && !page_prot) ? ST_OPEN : ST_LOCKED;
      end
      ST_OPEN: begin
        if (reg_wr) begin
          if (ctl_wr && reg_wdata == CMD_PAGE_ERASE && !page_prot) begin
            state_d      = ST_PERASE;
            start_perase = 1'b1;
          end else if (ctl_wr && reg_wdata == CMD_MASS_ERASE && !any_prot) begin
            state_d      = ST_MERASE;
            start_merase = 1'b1;
          end else begin
            state_d = ST_LOCKED;
          end
        end else if (prog_req) begin
          state_d    = ST_PROG;
          start_prog = 1'b1;
        end
      end
      ST_PROG, ST_PERASE, ST_MERASE: begin
        if (op_done) state_d = ST_LOCKED;
      end
      default: state_d = ST_LOCKED;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_LOCKED;
    else        state_q <= state_d;
  end

  // R2: the second step is only reachable from the first
  assert_step2_entry_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_STEP2 && $past(state_q) != ST_STEP2) |-> $past(state_q) == ST_STEP1);

  // R3: opening only follows the second step
  assert_open_entry_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_OPEN && $past(state_q) != ST_OPEN) |-> $past(state_q) == ST_STEP2);

  // R10: every busy phase ends in the locked state
  assert_relock_after_op_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state_q) inside {ST_PROG, ST_PERASE, ST_MERASE} &&
     !(state_q inside {ST_PROG, ST_PERASE, ST_MERASE})) |-> state_q == ST_LOCKED);
endmodule

// File: rtl/gac_op_timer.sv
module gac_op_timer #(
  parameter int FW          = 16,
  parameter int ERASE_SHIFT = 2,
  parameter int MASS_SHIFT  = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [FW-1:0] freq,
  input  logic          start_prog,
  input  logic          start_perase,
  input  logic          start_merase,
  output logic          active,
  output logic          op_done
);
  localparam int CW = FW + MASS_SHIFT + 1;

  logic [CW-1:0] cnt_q, cnt_d, base, load;
  logic          act_q, act_d;
  logic          start_any;

  assign start_any = start_prog | start_perase | start_merase;
  assign base      = (freq == '0) ? CW'(1) : CW'(freq);

  always_comb begin
    load = base;
    if (start_perase)      load = base << ERASE_SHIFT;
    else if (start_merase) load = base << MASS_SHIFT;
  end

  assign active  = act_q;
  assign op_done = act_q && (cnt_q == CW'(1));

  always_comb begin
    cnt_d = cnt_q;
    act_d = act_q;
    if (start_any) begin
      cnt_d = load;
      act_d = 1'b1;
    end else if (act_q) begin
      if (cnt_q == CW'(1)) begin
        cnt_d = '0;
        act_d = 1'b0;
      end else begin
        cnt_d = cnt_q - CW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      act_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      act_q <= act_d;
    end
  end

  // R11: no new operation may be launched while one is running
  assert_no_start_when_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
    start_any |-> !act_q);

  // R7: at most one start per cycle
  assert_single_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({start_prog, start_perase, start_merase}));
endmodule

// File: rtl/gac_array.sv
module gac_array #(
  parameter int MEM_BYTES  = 256,
  parameter int PAGE_BYTES = 16
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [$clog2(MEM_BYTES)-1:0]  rd_addr,
  output logic [7:0]                    rd_data,
  input  logic                          commit_prog,
  input  logic [$clog2(MEM_BYTES)-1:0]  prog_addr,
  input  logic [7:0]                    prog_data,
  input  logic                          commit_perase,
  input  logic [$clog2(MEM_BYTES/PAGE_BYTES)-1:0] erase_page,
  input  logic                          commit_merase
);
  localparam int AW  = $clog2(MEM_BYTES);
  localparam int OFW = $clog2(PAGE_BYTES);

  logic [7:0] mem_q [MEM_BYTES];
  logic [7:0] mem_d [MEM_BYTES];

  always_comb begin
    for (int i = 0; i < MEM_BYTES; i++) begin
      mem_d[i] = mem_q[i];
      if (commit_merase) begin
        mem_d[i] = 8'hFF;
      end else if (commit_perase && (AW'(i) >> OFW) == AW'(erase_page)) begin
        mem_d[i] = 8'hFF;
      end else if (commit_prog && prog_addr == AW'(i)) begin
        mem_d[i] = mem_q[i] & prog_data;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < MEM_BYTES; i++) mem_q[i] <= 8'hFF;
    end else if (commit_prog | commit_perase | commit_merase) begin
      for (int i = 0; i < MEM_BYTES; i++) mem_q[i] <= mem_d[i];
    end
  end

  assign rd_data = mem_q[rd_addr];

  // R6: programming never raises a bit that was clear
  assert_prog_only_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_prog && !commit_perase && !commit_merase) |=>
      ((mem_q[$past(prog_addr)] & ~$past(mem_q[prog_addr])) == 8'h00));
endmodule

// File: rtl/guarded_array_ctl.sv
module guarded_array_ctl
  import gac_pkg::*;
#(
  parameter int SECTORS      = 8,
  parameter int SECTOR_BYTES = 32,
  parameter int PAGE_BYTES   = 16,
  parameter int ERASE_SHIFT  = 2,
  parameter int MASS_SHIFT   = 3
) (
  input  logic                                    clk,
  input  logic                                    rst_n,
  input  logic                                    reg_wr,
  input  logic [2:0]                              reg_addr,
  input  logic [7:0]                              reg_wdata,
  output logic [7:0]                              reg_rdata,
  input  logic                                    mem_wr,
  input  logic [$clog2(SECTORS*SECTOR_BYTES)-1:0] mem_addr,
  input  logic [7:0]                              mem_wdata,
  output logic [7:0]                              mem_rdata,
  output logic                                    stall
);
  localparam int MEM_BYTES = SECTORS * SECTOR_BYTES;
  localparam int AW        = $clog2(MEM_BYTES);
  localparam int PAGES     = MEM_BYTES / PAGE_BYTES;
  localparam int PW        = $clog2(PAGES);
  localparam int SW        = (SECTORS > 1) ? $clog2(SECTORS) : 1;
  localparam int OFW       = $clog2(PAGE_BYTES);
  localparam int FW        = 16;

  // reset: asynchronous assertion, synchronous release
  logic rst_meta, rst_int;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_int  <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_int  <= rst_meta;
    end
  end

  gac_state_t     state_q;
  logic           start_prog, start_perase, start_merase;
  logic           tmr_active, op_done;
  logic           busy, is_open, prog_req;
  logic [7:0]     page_q, prot_q, fhi_q, flo_q;
  logic [7:0]     page_d, prot_d, fhi_d, flo_d;
  logic [AW-1:0]  paddr_q, paddr_d;
  logic [7:0]     pdata_q, pdata_d;
  logic [PW-1:0]  cur_page;
  logic [SW-1:0]  cur_sector;
  logic           page_prot, any_prot;

  assign busy     = state_q inside {ST_PROG, ST_PERASE, ST_MERASE};
  assign is_open  = (state_q == ST_OPEN);
  assign cur_page = page_q[PW-1:0];

  generate
    if (SECTORS > 1) begin : g_multi_sector
      assign cur_sector = cur_page[PW-1 -: SW];
    end else begin : g_one_sector
      assign cur_sector = '0;
    end
  endgenerate

  assign page_prot = prot_q[cur_sector];
  assign any_prot  = |prot_q[SECTORS-1:0];
  assign prog_req  = mem_wr && is_open && (mem_addr[AW-1:OFW] == cur_page);

  // register next-state
  always_comb begin
    page_d  = page_q;
    prot_d  = prot_q;
    fhi_d   = fhi_q;
    flo_d   = flo_q;
    paddr_d = paddr_q;
    pdata_d = pdata_q;
    if (reg_wr && !busy) begin
      if (reg_addr == RA_PAGE && state_q == ST_LOCKED) page_d = reg_wdata;
      if (reg_addr == RA_PROT) prot_d = prot_q | reg_wdata;
      if (reg_addr == RA_FHI)  fhi_d  = reg_wdata;
      if (reg_addr == RA_FLO)  flo_d  = reg_wdata;
    end
    if (start_prog) begin
      paddr_d = mem_addr;
      pdata_d = mem_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_int) begin
    if (!rst_int) begin
      page_q  <= '0;
      prot_q  <= '0;
      fhi_q   <= '0;
      flo_q   <= '0;
      paddr_q <= '0;
      pdata_q <= '0;
    end else begin
      page_q  <= page_d;
      prot_q  <= prot_d;
      fhi_q   <= fhi_d;
      flo_q   <= flo_d;
      paddr_q <= paddr_d;
      pdata_q <= pdata_d;
    end
  end

  gac_unlock_fsm u_fsm (
    .clk          (clk),
    .rst_n        (rst_int),
    .reg_wr       (reg_wr),
    .reg_addr     (reg_addr),
    .reg_wdata    (reg_wdata),
    .page_q       (page_q),
    .page_prot    (page_prot),
    .any_prot     (any_prot),
    .prog_req     (prog_req),
    .op_done      (op_done),
    .state_q      (state_q),
    .start_prog   (start_prog),
    .start_perase (start_perase),
    .start_merase (start_merase)
  );

  gac_op_timer #(
    .FW          (FW),
    .ERASE_SHIFT (ERASE_SHIFT),
    .MASS_SHIFT  (MASS_SHIFT)
  ) u_timer (
    .clk          (clk),
    .rst_n        (rst_int),
    .freq         ({fhi_q, flo_q}),
    .start_prog   (start_prog),
    .start_perase (start_perase),
    .start_merase (start_merase),
    .active       (tmr_active),
    .op_done      (op_done)
  );

  gac_array #(
    .MEM_BYTES  (MEM_BYTES),
    .PAGE_BYTES (PAGE_BYTES)
  ) u_array (
    .clk           (clk),
    .rst_n         (rst_int),
    .rd_addr       (mem_addr),
    .rd_data       (mem_rdata),
    .commit_prog   (op_done && state_q == ST_PROG),
    .prog_addr     (paddr_q),
    .prog_data     (pdata_q),
    .commit_perase (op_done && state_q == ST_PERASE),
    .erase_page    (cur_page),
    .commit_merase (op_done && state_q == ST_MERASE)
  );

  assign stall = (state_q == ST_PROG);

  always_comb begin
    case (reg_addr)
      RA_CTL:  reg_rdata = {5'b0, state_q};
      RA_PAGE: reg_rdata = page_q;
      RA_PROT: reg_rdata = prot_q;
      RA_FHI:  reg_rdata = fhi_q;
      RA_FLO:  reg_rdata = flo_q;
      default: reg_rdata = 8'h00;
    endcase
  end

  // R7: busy states and the operation timer agree cycle for cycle
  assert_busy_matches_timer_R7: assert property (@(posedge clk) disable iff (!rst_int)
    busy == tmr_active);

  // R5: the open state never coexists with a protected page
  assert_open_unprotected_R5: assert property (@(posedge clk) disable iff (!rst_int)
    is_open |-> !page_prot);

  // R11: the page selection cannot move during an operation
  assert_page_stable_busy_R11: assert property (@(posedge clk) disable iff (!rst_int)
    (busy && $past(busy)) |-> $stable(page_q));

  // R5: protection bits never drop once set
  assert_prot_sticky_R5: assert property (@(posedge clk) disable iff (!rst_int)
    (($past(prot_q) & ~prot_q) == 8'h00));
endmodule

// File: tb/sim_guarded_array_ctl.sv
module sim_guarded_array_ctl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0;
  logic [2:0] reg_addr = 3'd0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       mem_wr = 1'b0;
  logic [7:0] mem_addr = 8'h00;
  logic [7:0] mem_wdata = 8'h00;
  logic [7:0] mem_rdata;
  logic       stall;

  always #4 clk = ~clk;  // 125 MHz

  guarded_array_ctl u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_wr(mem_wr),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .stall(stall)
  );

  int    checks = 0;
  int    errors = 0;
  bit    done = 0;
  int    exp_q[$];
  string tag_q[$];
  int    probe_sel = 0;
  bit    probe_v = 0;
  int    meas = 0;

  // monitor: pops expected items and compares against sampled outputs
  always @(negedge clk) begin
    if (probe_v) begin
      int    act;
      int    exp;
      string tag;
      case (probe_sel)
        0: act = int'(reg_rdata);
        1: act = int'(mem_rdata);
        default: act = meas;
      endcase
      exp = exp_q.pop_front();
      tag = tag_q.pop_front();
      checks++;
      if (act != exp) begin
        errors++;
        $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
    end
  end

  task automatic push_probe(input int sel, input int exp, input string tag);
    probe_sel = sel;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    probe_v = 1;
    @(posedge clk); #1;
    probe_v = 0;
    reg_addr = 3'd0;
  endtask

  task automatic expect_reg(input logic [2:0] a, input int exp, input string tag);
    @(posedge clk); #1;
    reg_addr = a;
    push_probe(0, exp, tag);
  endtask

  task automatic expect_mem(input logic [7:0] a, input int exp, input string tag);
    @(posedge clk); #1;
    mem_addr = a;
    push_probe(1, exp, tag);
  endtask

  task automatic expect_meas(input int exp, input string tag);
    @(posedge clk); #1;
    push_probe(2, exp, tag);
  endtask

  task automatic reg_write(input logic [2:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_wr = 0; reg_addr = 3'd0;
  endtask

  task automatic mem_write(input logic [7:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    mem_wr = 1; mem_addr = a; mem_wdata = d;
    @(posedge clk); #1;
    mem_wr = 0;
  endtask

  task automatic both_write(input logic [7:0] d, input logic [7:0] ma, input logic [7:0] md);
    @(posedge clk); #1;
    reg_wr = 1; reg_addr = 3'd0; reg_wdata = d;
    mem_wr = 1; mem_addr = ma; mem_wdata = md;
    @(posedge clk); #1;
    reg_wr = 0; mem_wr = 0;
  endtask

  task automatic unlock(input logic [7:0] p);
    reg_write(3'd1, p);
    reg_write(3'd0, 8'h73);
    reg_write(3'd0, 8'h8C);
    reg_write(3'd1, p);
  endtask

  // counts cycles with stall (use_stall) or busy status bit high
  task automatic measure(input bit use_stall);
    meas = 0;
    @(negedge clk);
    while (use_stall ? stall : reg_rdata[2]) begin
      meas++;
      @(negedge clk);
    end
  endtask

  task automatic wait_idle();
    reg_addr = 3'd0;
    @(negedge clk);
    while (reg_rdata[2]) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    // R1 reset state
    expect_reg(3'd0, 0, "R1 status after reset");
    expect_reg(3'd1, 0, "R1 page after reset");
    expect_reg(3'd2, 0, "R1 protection after reset");
    expect_reg(3'd4, 0, "R1 freq low after reset");
    expect_mem(8'd0, 8'hFF, "R1 byte 0 erased");
    expect_mem(8'd255, 8'hFF, "R1 byte 255 erased");

    // R7 frequency = 5
    reg_write(3'd3, 8'h00);
    reg_write(3'd4, 8'h05);
    expect_reg(3'd4, 5, "R7 freq low readback");

    // R2 / R3 stepwise unlock of page 2
    reg_write(3'd1, 8'h02);
    reg_write(3'd0, 8'h73);
    expect_reg(3'd0, 1, "R2 first key");
    reg_write(3'd0, 8'h8C);
    expect_reg(3'd0, 2, "R2 second key");
    reg_write(3'd1, 8'h02);
    expect_reg(3'd0, 3, "R3 matching page opens");

    // R6 / R7 byte program with stall window
    mem_write(8'd35, 8'hA5);
    measure(1);
    expect_meas(5, "R7 program stall cycles");
    expect_reg(3'd0, 0, "R10 relock after program");
    expect_mem(8'd35, 8'hA5, "R6 programmed byte");

    unlock(8'h02);
    mem_write(8'd35, 8'h0F);
    expect_reg(3'd0, 4, "R6 program busy status");
    wait_idle();
    expect_mem(8'd35, 8'h05, "R6 program only clears bits");

    // R4 sequence breaks
    reg_write(3'd0, 8'h73);
    reg_write(3'd0, 8'h11);
    expect_reg(3'd0, 0, "R4 wrong second key");
    reg_write(3'd0, 8'h73);
    reg_write(3'd0, 8'h8C);
    reg_write(3'd4, 8'h05);
    expect_reg(3'd0, 0, "R4 foreign write in step 2");
    reg_write(3'd0, 8'h73);
    reg_write(3'd0, 8'h8C);
    reg_write(3'd1, 8'h03);
    expect_reg(3'd0, 0, "R3 mismatching page");
    expect_reg(3'd1, 2, "R3 page value kept");

    // R13 ignored array writes
    mem_write(8'd40, 8'h00);
    expect_mem(8'd40, 8'hFF, "R13 write while locked");
    unlock(8'h01);
    mem_write(8'd100, 8'h00);
    expect_mem(8'd100, 8'hFF, "R13 write outside page");
    expect_reg(3'd0, 3, "R13 stays open");
    mem_write(8'd20, 8'h3C);
    wait_idle();
    expect_mem(8'd20, 8'h3C, "R6 program page 1");

    // R8 page erase
    unlock(8'h02);
    reg_write(3'd0, 8'h95);
    measure(0);
    expect_meas(20, "R8 page erase busy cycles");
    expect_mem(8'd35, 8'hFF, "R8 page byte erased");
    expect_mem(8'd20, 8'h3C, "R8 other page untouched");
    expect_reg(3'd0, 0, "R10 relock after page erase");

    // R9 mass erase
    mem_write(8'd90, 8'h00);
    unlock(8'h05);
    mem_write(8'd90, 8'h12);
    wait_idle();
    unlock(8'h01);
    reg_write(3'd0, 8'h63);
    expect_reg(3'd0, 6, "R9 mass erase status");
    wait_idle();
    expect_mem(8'd20, 8'hFF, "R9 mass erase byte 20");
    expect_mem(8'd90, 8'hFF, "R9 mass erase byte 90");

    // R11 writes while busy
    unlock(8'h01);
    mem_write(8'd20, 8'h3C);
    wait_idle();
    unlock(8'h02);
    reg_write(3'd0, 8'h95);
    reg_write(3'd0, 8'h73);
    mem_write(8'd20, 8'h00);
    reg_write(3'd4, 8'h09);
    wait_idle();
    expect_reg(3'd0, 0, "R11 key ignored while busy");
    expect_mem(8'd20, 8'h3C, "R11 array write ignored while busy");
    expect_reg(3'd4, 5, "R11 freq write ignored while busy");

    // R12 simultaneous register and array write
    unlock(8'h02);
    both_write(8'h00, 8'd33, 8'h00);
    expect_reg(3'd0, 0, "R12 register write relocks");
    expect_mem(8'd33, 8'hFF, "R12 array write dropped");

    // R5 protection
    reg_write(3'd2, 8'h02);
    expect_reg(3'd2, 2, "R5 protect set");
    reg_write(3'd2, 8'h00);
    expect_reg(3'd2, 2, "R5 protect sticky");
    unlock(8'h02);
    expect_reg(3'd0, 0, "R5 protected page stays locked");
    unlock(8'h00);
    expect_reg(3'd0, 3, "R5 unprotected page opens");
    reg_write(3'd0, 8'h63);
    expect_reg(3'd0, 0, "R9 mass erase refused when protected");
    expect_mem(8'd20, 8'h3C, "R9 refused mass erase keeps data");

    repeat (3) @(posedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule